// File: doc/BRIEF.md
# Five-Phase Multicycle Register CPU Core

This core executes a small two-operand instruction set with four 8-bit general-purpose registers. Every instruction takes the same five control phases, one clock each: fetch, decode with register read, execute, memory access and write-back. After write-back the core returns to fetch. The phase has work to do for some instructions and none for others, but it is never skipped. The only exception is a stop instruction that has completed. Instruction and data storage sit outside the core on two separate synchronous ports. Each port has a one-cycle read latency, and the core holds the address steady while it waits.

Internally the core keeps a program counter, an instruction register, a memory address register and a memory data register. A direct-address load or store loads its address into the memory address register in the execute phase. It then drives that address in the memory-access phase. For a store, the memory data register holds the outgoing value. For a load, it captures the returned value in write-back. A testbench runs a program until the halted output rises. It then inspects data storage to see the results.

Top module: `cpu_core`

## Requirements
- R1: Out of reset the phase output steps 0 (fetch), 1 (decode), 2 (execute), 3 (memory), 4 (write-back) and back to 0, one phase per clock, for every instruction including no-operation codes.
- R2: While rst_ni is low the phase is 0, halted_o is 0, imem_addr_o is 0 and neither data strobe is asserted. Reset also clears all four registers.
- R3: An instruction word is {opcode[15:12], dst[11:10], src[9:8], field[7:0]}. The register codes are 0=AX, 1=BX, 2=CX, 3=DX. imem_addr_o equals the program counter, which starts at 0 and increments by one at the end of each fetch.
- R4: ADD (opcode 1) writes dst+src modulo 256 into dst, and src is left unchanged. When dst equals src the register doubles.
- R5: MOVI (opcode 2) writes the 8-bit field into dst and asserts no data strobe.
- R6: LOAD (opcode 3) asserts dmem_re_o for one cycle in the memory phase, with dmem_addr_o equal to the field. It writes the value returned one cycle later into dst.
- R7: STORE (opcode 4) asserts dmem_we_o for one cycle in the memory phase. It drives dmem_addr_o equal to the field and dmem_wdata_o equal to the src register.
- R8: Data strobes occur only in the memory phase. Opcodes other than 3 and 4 assert no data strobe.
- R9: HALT (opcode 15) raises halted_o at the end of its write-back. From then on the phase stays 0, imem_addr_o stays constant and no data strobe occurs until reset.
- R10: Opcodes 0, 5 to 14 pass through all five phases and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_addr_o | output | 8 | Instruction address (program counter) |
| imem_rdata_i | input | 16 | Instruction word, one cycle after the address |
| dmem_addr_o | output | 8 | Data address (memory address register) |
| dmem_re_o | output | 1 | Data read strobe |
| dmem_we_o | output | 1 | Data write strobe |
| dmem_wdata_o | output | 8 | Data to write |
| dmem_rdata_i | input | 8 | Read data, one cycle after the read strobe |
| phase_o | output | 3 | Current control phase |
| halted_o | output | 1 | Set after a HALT completes |

## Verification
The registers can be seen only through stores, so every register check is a program that ends by storing its registers into data storage. The bench then reads the stored values back. The hardest case is the load path, where the data arrives one cycle after the strobe, in the write-back phase. The bench preloads its synchronous data model, loads two values, adds them with a wrap-around, and stores the sum. A wrong capture cycle corrupts the stored result. Behaviour after halt is checked by holding the clock running for many cycles and watching the phase, the address and the strobes.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int OPC_W     = 4;
  localparam int NUM_REGS  = 4;
  localparam int REG_IDX_W = $clog2(NUM_REGS);
  localparam int INSTR_W   = OPC_W + 2 * REG_IDX_W + DATA_W;

  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h1;
  localparam logic [OPC_W-1:0] OPC_MOVI  = 4'h2;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h3;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h4;
  localparam logic [OPC_W-1:0] OPC_HALT  = 4'hF;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_EXEC   = 3'd2,
    PH_MEM    = 3'd3,
    PH_WB     = 3'd4
  } phase_e;

  typedef struct packed {
    logic [OPC_W-1:0]     opc;
    logic [REG_IDX_W-1:0] dst;
    logic [REG_IDX_W-1:0] src;
    logic [DATA_W-1:0]    field;
  } instr_t;
endpackage

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
  import cpu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opc_i,
  output phase_e           phase_o,
  output logic             halted_o,
  output logic             fetch_o,
  output logic             decode_o,
  output logic             exec_o,
  output logic             mar_load_o,
  output logic             mdr_from_reg_o,
  output logic             mdr_from_mem_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             reg_we_o
);
  phase_e phase_q, phase_d;
  logic   halted_q;
  logic   is_load, is_store, writes_reg;

  assign is_load    = (opc_i == OPC_LOAD);
  assign is_store   = (opc_i == OPC_STORE);
  assign writes_reg = (opc_i == OPC_ADD) || (opc_i == OPC_MOVI) || is_load;

  always_comb begin
    unique case (phase_q)
      PH_FETCH:  phase_d = halted_q ? PH_FETCH : PH_DECODE;
      PH_DECODE: phase_d = PH_EXEC;
      PH_EXEC:   phase_d = PH_MEM;
      PH_MEM:    phase_d = PH_WB;
      default:   phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_FETCH;
      halted_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_WB && opc_i == OPC_HALT) halted_q <= 1'b1;
    end
  end

  assign phase_o        = phase_q;
  assign halted_o       = halted_q;
  assign fetch_o        = (phase_q == PH_FETCH) && !halted_q;
  assign decode_o       = (phase_q == PH_DECODE);
  assign exec_o         = (phase_q == PH_EXEC);
  assign mar_load_o     = exec_o && (is_load || is_store);
  assign mdr_from_reg_o = exec_o && is_store;
  assign mem_rd_o       = (phase_q == PH_MEM) && is_load;
  assign mem_wr_o       = (phase_q == PH_MEM) && is_store;
  assign mdr_from_mem_o = (phase_q == PH_WB) && is_load;
  assign reg_we_o       = (phase_q == PH_WB) && writes_reg;

  assert_phase_order_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_MEM) |=> (phase_q == PH_WB));
  assert_wb_returns_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WB) |=> (phase_q == PH_FETCH));
  assert_strobe_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  assert_halt_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> (halted_q && phase_q == PH_FETCH));
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import cpu_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int N = NUM_REGS,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] raddr_a_i,
  input  logic [IW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o
);
  logic [N-1:0][W-1:0] regs;

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q <= '0;
      else if (we_i && waddr_i == IW'(i))     q <= wdata_i;
    end
    assign regs[i] = q;
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [OPC_W-1:0] opc_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [W-1:0]     imm_i,
  output logic [W-1:0]     y_o
);
  // sum wraps: carry is discarded
  assign y_o = (opc_i == OPC_ADD) ? W'(a_i + b_i) : imm_i;
endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [ADDR_W-1:0]  imem_addr_o,
  input  logic [INSTR_W-1:0] imem_rdata_i,
  output logic [ADDR_W-1:0]  dmem_addr_o,
  output logic               dmem_re_o,
  output logic               dmem_we_o,
  output logic [DATA_W-1:0]  dmem_wdata_o,
  input  logic [DATA_W-1:0]  dmem_rdata_i,
  output logic [2:0]         phase_o,
  output logic               halted_o
);
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mdr_q, opa_q, opb_q, res_q;
  instr_t            ir_q;
  phase_e            phase;
  logic fetch, decode, exec, mar_load, mdr_from_reg, mdr_from_mem, mem_rd, mem_wr, reg_we;
  logic [DATA_W-1:0] rd_a, rd_b, alu_y, wb_data;

  cpu_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .opc_i(ir_q.opc),
    .phase_o(phase), .halted_o(halted_o), .fetch_o(fetch), .decode_o(decode),
    .exec_o(exec), .mar_load_o(mar_load), .mdr_from_reg_o(mdr_from_reg),
    .mdr_from_mem_o(mdr_from_mem), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .reg_we_o(reg_we)
  );

  assign wb_data = (ir_q.opc == OPC_LOAD) ? dmem_rdata_i : res_q;

  cpu_regfile #(.W(DATA_W), .N(NUM_REGS)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we), .waddr_i(ir_q.dst),
    .wdata_i(wb_data), .raddr_a_i(ir_q.dst), .raddr_b_i(ir_q.src),
    .rdata_a_o(rd_a), .rdata_b_o(rd_b)
  );

  cpu_alu #(.W(DATA_W)) u_alu (
    .opc_i(ir_q.opc), .a_i(opa_q), .b_i(opb_q), .imm_i(ir_q.field), .y_o(alu_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      opa_q <= '0;
      opb_q <= '0;
      res_q <= '0;
    end else begin
      if (fetch) begin
        ir_q <= imem_rdata_i;
        pc_q <= pc_q + 1'b1;
      end
      if (decode) begin
        opa_q <= rd_a;
        opb_q <= rd_b;
      end
      if (exec)         res_q <= alu_y;
      if (mar_load)     mar_q <= ir_q.field;
      if (mdr_from_reg) mdr_q <= opb_q;
      if (mdr_from_mem) mdr_q <= dmem_rdata_i;
    end
  end

  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = mar_q;
  assign dmem_wdata_o = mdr_q;
  assign dmem_re_o    = mem_rd;
  assign dmem_we_o    = mem_wr;
  assign phase_o      = phase;

  assert_pc_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_FETCH && !halted_o) |=> (pc_q == $past(pc_q) + 1'b1));
  assert_pc_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_FETCH) |=> $stable(pc_q));
  assert_strobe_phase_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_re_o || dmem_we_o) |-> (phase == PH_MEM));
  assert_mem_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_re_o || dmem_we_o) |-> (dmem_addr_o == ir_q.field));
  assert_no_strobe_halted_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !(dmem_re_o || dmem_we_o));
endmodule

// File: tb/tb_cpu_core.sv
`timescale 1ns/1ps
module tb_cpu_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  imem_addr, dmem_addr, dmem_wdata, dmem_q;
  logic [15:0] imem_q;
  logic        dmem_re, dmem_we, halted;
  logic [2:0]  phase;

  logic [15:0] imem [256];
  logic [7:0]  dmem [256];

  int n_tests = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0, off_phase_cnt = 0;
  logic [7:0] last_rd_addr = '0;

  always #2.5 clk = ~clk;

  cpu_core dut (
    .clk_i(clk), .rst_ni(rst_ni), .imem_addr_o(imem_addr), .imem_rdata_i(imem_q),
    .dmem_addr_o(dmem_addr), .dmem_re_o(dmem_re), .dmem_we_o(dmem_we),
    .dmem_wdata_o(dmem_wdata), .dmem_rdata_i(dmem_q), .phase_o(phase), .halted_o(halted)
  );

  always @(posedge clk) begin
    imem_q <= imem[imem_addr];
    dmem_q <= dmem[dmem_addr];
    if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      if (dmem_re) begin rd_cnt++; last_rd_addr = dmem_addr; end
      if (dmem_we) wr_cnt++;
      if ((dmem_re || dmem_we) && phase != 3'd3) off_phase_cnt++;
    end
  end

  function automatic logic [15:0] enc(logic [3:0] op, logic [1:0] d, logic [1:0] s, logic [7:0] f);
    return {op, d, s, f};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin imem[i] = 16'hF000; dmem[i] = 8'h00; end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic run(input int max_cycles);
    int c = 0;
    while (!halted && c < max_cycles) begin @(negedge clk); c++; end
    check(halted == 1'b1, "R9 program halts", {31'd0, halted}, 1);
  endtask

  task automatic t_reset();
    clear_mem();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(phase == 3'd0, "R2 phase in reset", phase, 0);
    check(halted == 1'b0, "R2 halted in reset", halted, 0);
    check(imem_addr == 8'd0, "R2 pc in reset", imem_addr, 0);
    check(!dmem_re && !dmem_we, "R2 strobes in reset", {dmem_re, dmem_we}, 0);
  endtask

  task automatic t_sequence();
    clear_mem();
    imem[0] = enc(4'h2, 2'd0, 2'd0, 8'h05);
    imem[1] = enc(4'hF, 2'd0, 2'd0, 8'h00);
    do_reset();
    for (int k = 0; k < 10; k++) begin
      check(phase == 3'(k % 5), "R1 phase order", phase, k % 5);
      if (k == 1) check(imem_addr == 8'd1, "R3 pc after first fetch", imem_addr, 1);
      if (k == 6) check(imem_addr == 8'd2, "R3 pc after second fetch", imem_addr, 2);
      @(negedge clk);
    end
    check(halted == 1'b1, "R9 halted after write-back", halted, 1);
    check(phase == 3'd0, "R9 phase after halt", phase, 0);
  endtask

  task automatic t_movi_store();
    int r0, w0;
    clear_mem();
    imem[0] = enc(4'h2, 2'd0, 2'd0, 8'h3C);
    imem[1] = enc(4'h2, 2'd1, 2'd0, 8'hA5);
    imem[2] = enc(4'h2, 2'd3, 2'd0, 8'hFF);
    imem[3] = enc(4'h4, 2'd0, 2'd0, 8'h10);
    imem[4] = enc(4'h4, 2'd0, 2'd1, 8'h11);
    imem[5] = enc(4'h4, 2'd0, 2'd3, 8'h12);
    imem[6] = enc(4'h4, 2'd0, 2'd2, 8'h13);
    do_reset();
    r0 = rd_cnt; w0 = wr_cnt;
    run(200);
    check(dmem[8'h10] == 8'h3C, "R5 MOVI AX", dmem[8'h10], 8'h3C);
    check(dmem[8'h11] == 8'hA5, "R5 MOVI BX", dmem[8'h11], 8'hA5);
    check(dmem[8'h12] == 8'hFF, "R7 store DX", dmem[8'h12], 8'hFF);
    check(dmem[8'h13] == 8'h00, "R2 CX cleared by reset", dmem[8'h13], 0);
    check(rd_cnt - r0 == 0, "R5 R8 no reads", rd_cnt - r0, 0);
    check(wr_cnt - w0 == 4, "R7 write count", wr_cnt - w0, 4);
  endtask

  task automatic t_add();
    clear_mem();
    imem[0] = enc(4'h2, 2'd0, 2'd0, 8'hF0);
    imem[1] = enc(4'h2, 2'd1, 2'd0, 8'h25);
    imem[2] = enc(4'h1, 2'd0, 2'd1, 8'h00);
    imem[3] = enc(4'h2, 2'd2, 2'd0, 8'h81);
    imem[4] = enc(4'h1, 2'd2, 2'd2, 8'h00);
    imem[5] = enc(4'h4, 2'd0, 2'd0, 8'h20);
    imem[6] = enc(4'h4, 2'd0, 2'd1, 8'h21);
    imem[7] = enc(4'h4, 2'd0, 2'd2, 8'h22);
    do_reset();
    run(200);
    check(dmem[8'h20] == 8'h15, "R4 add wraps into dst", dmem[8'h20], 8'h15);
    check(dmem[8'h21] == 8'h25, "R4 src unchanged", dmem[8'h21], 8'h25);
    check(dmem[8'h22] == 8'h02, "R4 self add doubles", dmem[8'h22], 8'h02);
  endtask

  task automatic t_load();
    int r0;
    clear_mem();
    dmem[8'h40] = 8'h77;
    dmem[8'h41] = 8'h9E;
    imem[0] = enc(4'h3, 2'd3, 2'd0, 8'h40);
    imem[1] = enc(4'h3, 2'd0, 2'd0, 8'h41);
    imem[2] = enc(4'h1, 2'd3, 2'd0, 8'h00);
    imem[3] = enc(4'h4, 2'd0, 2'd3, 8'h50);
    imem[4] = enc(4'h4, 2'd0, 2'd0, 8'h51);
    do_reset();
    r0 = rd_cnt;
    repeat (5) @(negedge clk);
    // first load's memory phase is sampled at negedge 3 of its window
    check(rd_cnt - r0 == 1 && last_rd_addr == 8'h40, "R6 read address", last_rd_addr, 8'h40);
    run(200);
    check(dmem[8'h50] == 8'h15, "R6 loaded sum", dmem[8'h50], 8'h15);
    check(dmem[8'h51] == 8'h9E, "R6 loaded value", dmem[8'h51], 8'h9E);
    check(rd_cnt - r0 == 2, "R6 read count", rd_cnt - r0, 2);
    check(off_phase_cnt == 0, "R8 strobes only in memory phase", off_phase_cnt, 0);
  endtask

  task automatic t_nop_codes();
    clear_mem();
    imem[0] = enc(4'h2, 2'd0, 2'd0, 8'h11);
    imem[1] = enc(4'h5, 2'd0, 2'd0, 8'hEE);
    imem[2] = enc(4'h0, 2'd0, 2'd0, 8'hDD);
    imem[3] = enc(4'hE, 2'd0, 2'd0, 8'hCC);
    imem[4] = enc(4'h4, 2'd0, 2'd0, 8'h60);
    do_reset();
    repeat (10) @(negedge clk);
    check(phase == 3'd0 && imem_addr == 8'd2, "R10 R1 nop takes five phases", {imem_addr, phase}, {8'd2, 3'd0});
    run(200);
    check(dmem[8'h60] == 8'h11, "R10 unused opcodes keep AX", dmem[8'h60], 8'h11);
  endtask

  task automatic t_halt_freeze();
    logic [7:0] a0;
    int w0, r0;
    clear_mem();
    imem[0] = enc(4'hF, 2'd0, 2'd0, 8'h00);
    imem[1] = enc(4'h4, 2'd0, 2'd0, 8'h70);
    do_reset();
    run(50);
    a0 = imem_addr; w0 = wr_cnt; r0 = rd_cnt;
    repeat (30) @(negedge clk);
    check(phase == 3'd0, "R9 phase frozen", phase, 0);
    check(imem_addr == a0, "R9 pc frozen", imem_addr, a0);
    check(wr_cnt == w0 && rd_cnt == r0, "R9 no strobes after halt", wr_cnt - w0, 0);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_sequence();
    t_movi_store();
    t_add();
    t_load();
    t_nop_codes();
    t_halt_freeze();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule